// File: doc/BRIEF.md
# Single-Device Serial Identity Reader

This block reads the 64-bit factory identity from one serial-number chip attached to a single open-drain data line. Right after reset it runs the whole exchange on its own: a long bus-reset low, a check for the device's answering low pulse, the one-byte "read identity" command, and then 64 read time slots. All bus timing is measured in microsecond ticks, which a counter derives from the system clock by a configurable divide ratio.

Each received byte appears on an 8-bit output together with a valid strobe. The strobe lasts about 20 µs, and the byte stays constant for as long as it is high. The six middle bytes are also collected into a 48-bit parallel serial field. A bit-serial CRC-8 runs over the whole frame, and a single status flag goes high when the frame is complete and its check byte is consistent. The line is modelled as a "pull low" output plus a sampled input. The pad, its pull-up and the wired-AND are outside the block.

Top module: `owid_reader`

## Requirements
- R1: After synchronous reset is released, `bus_low` is asserted for RESET_US (default 480) microsecond ticks and then released.
- R2: The line is sampled PRES_US (70) µs after the reset low ends. If it reads high there (no device), the block stops with `bus_low` released, produces no strobe, and `id_good` stays 0.
- R3: The command byte 0x33 is sent LSB first in slots of SLOT_US (70) µs. A 1 bit is a low of W1_LOW_US (6) µs and a 0 bit is a low of W0_LOW_US (60) µs.
- R4: Each of the 64 read slots drives the line low for RD_LOW_US (6) µs and samples it SAMPLE_US (15) µs into the slot. Bits fill each byte LSB first.
- R5: Exactly eight strobes follow each reset, in frame order: byte 0 is the family code (0x01 for the target chip), bytes 1 to 6 are the serial number, and byte 7 is the CRC.
- R6: `byte_strobe` stays high for STROBE_US (20) µs, and `byte_out` is stable while it is high.
- R7: After the frame, `serial_out` holds bytes 1 to 6, with byte 1 in bits 7:0 and byte 6 in bits 47:40.
- R8: The CRC register starts at zero and processes bits LSB first: shift right, and XOR 0x8C when the input bit XOR the register LSB is 1. `id_good` rises only after all 64 bits, and only when the residue over the eight bytes is zero. Otherwise it stays 0.
- R9: While reset is high, `bus_low`, `byte_strobe`, `id_good` and `serial_out` are all 0.
- R10: One microsecond tick equals TICK_DIV system clocks, so every bus interval scales by that ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a new read |
| line_in | input | 1 | Sampled level of the data line |
| bus_low | output | 1 | 1 = pull the data line low, 0 = release it |
| byte_out | output | 8 | Most recently received byte |
| byte_strobe | output | 1 | Valid strobe for `byte_out` |
| serial_out | output | 48 | Six serial-number bytes |
| id_good | output | 1 | Frame complete and CRC residue zero |

## Verification
Every interval is an integer number of ticks of TICK_DIV clocks. The bench therefore expects the reset low to be 480 ticks long, every slot to start 70 ticks after the previous one, write lows of 6 or 60 ticks, and a strobe of 20 ticks, each allowing one tick of slack for tick phase. A behavioural device in the bench decodes each command bit from the length of the low it sees and answers each read slot by holding the line low for 30 µs, so the sample at 15 µs, delayed by the two synchronizer stages, falls well inside that window. Strobe contents are compared on every falling clock edge against a queue of expected bytes. The serial field and `id_good` are checked about 200 µs after the last slot, by which time the one-cycle CHECK step has long finished.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [2:0] {
    S_RST_LOW,
    S_RST_WAIT,
    S_CMD,
    S_READ,
    S_CHECK,
    S_DONE,
    S_NODEV
  } owid_state_t;

  // one bit of the reflected CRC-8 (x^8+x^5+x^4+1)
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b, input logic [7:0] poly_r);
    logic fb;
    fb = b ^ c[0];
    return (c >> 1) ^ (fb ? poly_r : 8'h00);
  endfunction

endpackage

// File: rtl/owid_tick.sv
module owid_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (DIV > 1) begin : g_gap
      // R10: ticks are separated by idle clocks when dividing
      a_r10_tick_gap: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/owid_sync.sv
module owid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '1;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/owid_crc8.sv
module owid_crc8
  import owid_pkg::*;
#(
  parameter logic [7:0] POLY_R = 8'h8C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       bit_in,
  output logic [7:0] crc
);
  always_ff @(posedge clk) begin
    if (rst)     crc <= 8'h00;
    else if (en) crc <= crc8_step(crc, bit_in, POLY_R);
  end
endmodule

// File: rtl/owid_present.sv
module owid_present #(
  parameter int HOLD_US = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] data,
  output logic [7:0] byte_out,
  output logic       strobe
);
  localparam int HW = $clog2(HOLD_US + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_US - 1);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out <= 8'h00;
      strobe   <= 1'b0;
      hcnt     <= '0;
    end else if (load) begin
      byte_out <= data;
      strobe   <= 1'b1;
      hcnt     <= '0;
    end else if (strobe && tick) begin
      if (hcnt == HOLD_END) strobe <= 1'b0;
      else                  hcnt   <= hcnt + 1'b1;
    end
  end

  // R6: byte held while strobe is high
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (strobe && $past(strobe) && !$past(load)) |-> $stable(byte_out));
endmodule

// File: rtl/owid_reader.sv
module owid_reader
  import owid_pkg::*;
#(
  parameter int         TICK_DIV    = 125,
  parameter int         SYNC_STAGES = 2,
  parameter int         RESET_US    = 480,
  parameter int         PRES_US     = 70,
  parameter int         RECOVER_US  = 480,
  parameter int         SLOT_US     = 70,
  parameter int         W1_LOW_US   = 6,
  parameter int         W0_LOW_US   = 60,
  parameter int         RD_LOW_US   = 6,
  parameter int         SAMPLE_US   = 15,
  parameter int         STROBE_US   = 20,
  parameter logic [7:0] ROM_CMD     = 8'h33
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        line_in,
  output logic        bus_low,
  output logic [7:0]  byte_out,
  output logic        byte_strobe,
  output logic [47:0] serial_out,
  output logic        id_good
);
  localparam int ROM_BYTES    = 8;
  localparam int ROM_BITS     = ROM_BYTES * 8;
  localparam int SERIAL_BYTES = 6;
  localparam int BW           = $clog2(ROM_BITS);
  localparam int MAX_US_A     = (RESET_US > RECOVER_US) ? RESET_US : RECOVER_US;
  localparam int MAX_US       = (MAX_US_A > SLOT_US) ? MAX_US_A : SLOT_US;
  localparam int CW           = $clog2(MAX_US + 1);

  localparam logic [CW-1:0] RST_END  = CW'(RESET_US - 1);
  localparam logic [CW-1:0] PRES_AT  = CW'(PRES_US);
  localparam logic [CW-1:0] REC_END  = CW'(RECOVER_US - 1);
  localparam logic [CW-1:0] SLOT_END = CW'(SLOT_US - 1);
  localparam logic [CW-1:0] W1_C     = CW'(W1_LOW_US);
  localparam logic [CW-1:0] W0_C     = CW'(W0_LOW_US);
  localparam logic [CW-1:0] RDL_C    = CW'(RD_LOW_US);
  localparam logic [CW-1:0] SAMP_AT  = CW'(SAMPLE_US);
  localparam logic [BW-1:0] LAST_BIT = BW'(ROM_BITS - 1);

  owid_state_t   state;
  logic [CW-1:0] us_cnt;
  logic [BW-1:0] bit_idx;
  logic          present;
  logic [7:0]    shreg;
  logic          tick;
  logic          line_s;
  logic          drive_c;
  logic          samp;
  logic          byte_done;
  logic [7:0]    new_byte;
  logic [7:0]    crc;

  owid_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  owid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  assign samp      = tick && (state == S_READ) && (us_cnt == SAMP_AT);
  assign new_byte  = {line_s, shreg[7:1]};
  assign byte_done = samp && (bit_idx[2:0] == 3'd7);

  owid_crc8 #(.POLY_R(8'h8C)) u_crc (
    .clk(clk), .rst(rst), .en(samp), .bit_in(line_s), .crc(crc)
  );

  owid_present #(.HOLD_US(STROBE_US)) u_present (
    .clk(clk), .rst(rst), .tick(tick), .load(byte_done), .data(new_byte),
    .byte_out(byte_out), .strobe(byte_strobe)
  );

  // line drive for the current slot position
  always_comb begin
    drive_c = 1'b0;
    case (state)
      S_RST_LOW: drive_c = 1'b1;
      S_CMD:     drive_c = ROM_CMD[bit_idx[2:0]] ? (us_cnt < W1_C) : (us_cnt < W0_C);
      S_READ:    drive_c = (us_cnt < RDL_C);
      default:   drive_c = 1'b0;
    endcase
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_RST_LOW;
      us_cnt  <= '0;
      bit_idx <= '0;
      present <= 1'b0;
      shreg   <= 8'h00;
      id_good <= 1'b0;
      bus_low <= 1'b0;
    end else begin
      bus_low <= drive_c;
      if (state == S_CHECK) begin
        id_good <= (crc == 8'h00);
        state   <= S_DONE;
      end else if (tick) begin
        case (state)
          S_RST_LOW: begin
            if (us_cnt == RST_END) begin
              state  <= S_RST_WAIT;
              us_cnt <= '0;
            end else us_cnt <= us_cnt + 1'b1;
          end
          S_RST_WAIT: begin
            if (us_cnt == PRES_AT) present <= ~line_s;
            if (us_cnt == REC_END) begin
              state   <= present ? S_CMD : S_NODEV;
              us_cnt  <= '0;
              bit_idx <= '0;
            end else us_cnt <= us_cnt + 1'b1;
          end
          S_CMD: begin
            if (us_cnt == SLOT_END) begin
              us_cnt <= '0;
              if (bit_idx[2:0] == 3'd7) begin
                state   <= S_READ;
                bit_idx <= '0;
              end else bit_idx <= bit_idx + 1'b1;
            end else us_cnt <= us_cnt + 1'b1;
          end
          S_READ: begin
            if (samp) shreg <= new_byte;
            if (us_cnt == SLOT_END) begin
              us_cnt <= '0;
              if (bit_idx == LAST_BIT) state <= S_CHECK;
              else                     bit_idx <= bit_idx + 1'b1;
            end else us_cnt <= us_cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // serial field: frame byte j (1..6) lands in slice j-1
  always_ff @(posedge clk) begin
    if (rst) serial_out <= '0;
    else if (byte_done) begin
      for (int j = 1; j <= SERIAL_BYTES; j++) begin
        if (bit_idx[BW-1:3] == 3'(j)) serial_out[(j-1)*8 +: 8] <= new_byte;
      end
    end
  end

  // R1: reset low is held throughout the reset phase
  a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
    (state == S_RST_LOW && !$past(rst)) |-> bus_low);

  // R2: with no device the line stays released and nothing is strobed
  a_r2_idle_absent: assert property (@(posedge clk) disable iff (rst)
    (state == S_NODEV && $past(state) == S_NODEV) |-> (!bus_low && !byte_strobe));

  // R4: the master has released the line when a read bit is taken
  a_r4_sample_released: assert property (@(posedge clk) disable iff (rst)
    samp |-> !bus_low);

  // R5: strobes only start during the receive phase
  a_r5_strobe_in_read: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_strobe) |-> (state == S_READ || state == S_CHECK));

  // R8: identity flag only once the frame is finished
  a_r8_good_when_done: assert property (@(posedge clk) disable iff (rst)
    id_good |-> (state == S_DONE));
endmodule

// File: tb/owid_reader_test.sv
module owid_reader_test;
  localparam int D = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        dev_low = 1'b0;
  logic        line;
  logic        bus_low;
  logic [7:0]  byte_out;
  logic        byte_strobe;
  logic [47:0] serial_out;
  logic        id_good;

  assign line = !(bus_low || dev_low);

  owid_reader #(.TICK_DIV(D)) uut (
    .clk(clk), .rst(rst), .line_in(line), .bus_low(bus_low),
    .byte_out(byte_out), .byte_strobe(byte_strobe),
    .serial_out(serial_out), .id_good(id_good)
  );

  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural device ----------------
  int          phase = 0;
  bit          dev_on = 1'b0;
  logic [63:0] rom = '0;
  longint      rst_width = 0;
  int          drv_edges = 0;

  initial begin
    longint t0, tprev, w;
    int     bitn;
    logic   b;
    logic [7:0] cmd_got;
    bitn = 0; tprev = 0; cmd_got = 0;
    forever begin
      @(posedge bus_low);
      t0 = cyc;
      drv_edges++;
      if (phase == 0) begin
        @(negedge bus_low);
        rst_width = cyc - t0;
        if (rst_width >= 400 * D && dev_on) begin
          repeat (20 * D) @(posedge clk);
          dev_low = 1'b1;
          repeat (100 * D) @(posedge clk);
          dev_low = 1'b0;
          phase = 1;
          bitn  = 0;
        end
      end else if (phase == 1) begin
        @(negedge bus_low);
        w = cyc - t0;
        b = (w < 30 * D);
        if (b) chk(w >= 6*D-2 && w <= 6*D+2, "R3", "write-1 low width", w, 6*D);
        else   chk(w >= 60*D-2 && w <= 60*D+2, "R3", "write-0 low width", w, 60*D);
        if (bitn > 0) chk(t0 - tprev >= 70*D-1 && t0 - tprev <= 70*D+1, "R3", "slot period", t0 - tprev, 70*D);
        tprev = t0;
        cmd_got[bitn] = b;
        bitn++;
        if (bitn == 8) begin
          chk(cmd_got == 8'h33, "R3", "command byte", cmd_got, 8'h33);
          phase = 2;
          bitn  = 0;
        end
      end else if (bitn < 64) begin
        b = rom[bitn];
        if (!b) dev_low = 1'b1;
        @(negedge bus_low);
        w = cyc - t0;
        if (bitn % 8 == 0) chk(w >= 6*D-2 && w <= 6*D+2, "R4", "read slot low width", w, 6*D);
        if (!b) begin
          while (cyc - t0 < 30 * D) @(posedge clk);
          dev_low = 1'b0;
        end
        bitn++;
      end
    end
  end

  // ---------------- per-clock reference comparison ----------------
  logic [7:0] exp_bytes [8];
  int         sidx = 0;
  int         scount = 0;
  longint     slen = 0;
  logic [7:0] held = 0;
  bit         prev_strobe = 0;
  bit         may_good = 0;
  bit         good_seen = 0;
  bit         early_flag = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_strobe && !prev_strobe) begin
        scount++;
        slen = 1;
        held = byte_out;
        if (sidx < 8) chk(byte_out == exp_bytes[sidx], "R5", "strobed byte", byte_out, exp_bytes[sidx]);
        else chk(1'b0, "R5", "extra strobe", scount, 8);
      end else if (byte_strobe) begin
        slen++;
        if (byte_out != held) chk(1'b0, "R6", "byte changed under strobe", byte_out, held);
      end
      if (!byte_strobe && prev_strobe) begin
        chk(slen >= 19*D && slen <= 21*D, "R6", "strobe width", slen, 20*D);
        sidx++;
        if (sidx == 8) may_good = 1;
      end
      if (id_good && !may_good && !early_flag) begin
        early_flag = 1;
        chk(1'b0, "R8", "id_good before frame end", 1, 0);
      end
      if (good_seen && !id_good) chk(1'b0, "R8", "id_good dropped", 0, 1);
      good_seen = id_good;
      prev_strobe = byte_strobe;
    end
  end

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c;
    logic       mix;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      mix = c[0] ^ d[i];
      c = c >> 1;
      if (mix) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] build(input logic [47:0] sn, input bit corrupt);
    logic [55:0] d;
    logic [7:0]  c;
    d = {sn, 8'h01};
    c = ref_crc(d);
    if (corrupt) c = c ^ 8'h5A;
    return {c, d};
  endfunction

  task automatic run(input bit on, input logic [63:0] r, input bit good_exp);
    dev_on = on;
    rom = r;
    phase = 0;
    drv_edges = 0;
    for (int k = 0; k < 8; k++) exp_bytes[k] = r[8*k +: 8];
    sidx = 0; scount = 0; may_good = 0; early_flag = 0; good_seen = 0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(bus_low == 0 && byte_strobe == 0, "R9", "reset bus/strobe", {bus_low, byte_strobe}, 0);
    chk(id_good == 0 && serial_out == 0, "R9", "reset id/serial", serial_out, 0);
    rst = 1'b0;
    repeat (6200 * D) @(posedge clk);
    @(negedge clk);
    chk(rst_width >= 479*D && rst_width <= 481*D, "R1", "reset low width", rst_width, 480*D);
    chk(rst_width % D <= 1 || rst_width % D == D-1, "R10", "width multiple of tick", rst_width % D, 0);
    if (on) begin
      chk(scount == 8, "R5", "strobe count", scount, 8);
      chk(serial_out == r[55:8], "R7", "serial field", serial_out, r[55:8]);
      chk(id_good == good_exp, "R8", "id_good", id_good, good_exp);
    end else begin
      chk(scount == 0, "R2", "strobes without device", scount, 0);
      chk(id_good == 0 && bus_low == 0, "R2", "idle outputs", {id_good, bus_low}, 0);
      chk(drv_edges == 1, "R2", "drive pulses without device", drv_edges, 1);
    end
  endtask

  initial begin
    run(1'b1, build(48'hF6E5D4C3B2A1, 1'b0), 1'b1);
    run(1'b1, build(48'h0123456789AB, 1'b1), 1'b0);
    run(1'b0, build(48'h0123456789AB, 1'b0), 1'b0);
    run(1'b1, build(48'h80FF00550AA1, 1'b0), 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule